// File: doc/BRIEF.md
# Transactional Rename Snapshot Manager

This block owns the register rename table of an out-of-order core and lets it return to the state it had when a hardware transaction started. Decode events update the table: a rename points an architectural register at a new physical register, and a transaction-begin copies the table, its companion saved-register vector and the handler address into a single pending snapshot. When that transaction-begin graduates, the pending snapshot becomes the active snapshot. A transaction-begin that graduates while a transaction is already active is folded into the outer transaction and only raises a nesting depth.

While a snapshot is active, physical registers from its saved set that graduation would free are held on a reserved list. This keeps the rollback state alive for any number of instructions. When the outermost transaction-end graduates, all reserved registers are released to the free list in one cycle. An abort instead restores the table and saved vector from the active snapshot, drops the reserved list and any pending snapshot, and presents the captured handler address for the fetch redirect. A transaction-begin decoded during an active transaction can be captured, so execution may run ahead into the next transaction. That snapshot is promoted when its own begin graduates after the current one commits.

Top module: `txsnap_top`

## Requirements
- R1: After reset, architectural register i maps to physical register i, no transaction is active, the reserved list is empty, and no free or abort pulse is driven.
- R2: A rename with no effective abort in the same cycle shows up in the mapping output one cycle later. Slot a occupies bits [a*PW +: PW] of the mapping output, where PW is the physical index width.
- R3: The saved vector has one bit per physical register. It is set for exactly the registers held by the table, so its population count always equals the number of architectural registers.
- R4: A decoded transaction-begin captures the table as it was before any rename in the same cycle, along with the handler address. By itself it does not change the active flag.
- R5: A graduating transaction-begin with no active transaction and a valid pending snapshot raises the active flag one cycle later.
- R6: A freed register that is in the active snapshot's saved set sets its bit in the reserved output one cycle later and does not appear in the free mask. Any other freed register pulses its bit in the free mask one cycle later.
- R7: The outermost transaction-end clears the active flag one cycle later. In that same cycle it pulses every reserved register, together with any register freed alongside it, in the free mask and empties the reserved list.
- R8: An abort while a transaction is active gives, one cycle later: the snapshot mapping, a one-cycle restore pulse, the captured handler address, the active flag low and an empty reserved list. Renames and frees in the abort cycle are discarded.
- R9: An abort with no active transaction has no effect. Other events in that cycle are processed normally.
- R10: A transaction-begin graduating during an active transaction creates no snapshot. Its matching transaction-end keeps the transaction active, and the reserved list is kept.
- R11: A transaction-begin decoded during an active transaction is captured if the pending slot is free. After the commit, its graduation activates it, and a later abort restores that later snapshot.
- R12: No register is ever in the free mask and the reserved output at the same time. The reserved list never holds more entries than there are architectural registers.
- R13: A decoded transaction-begin is dropped when the pending slot is full and is not emptied in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| renValid | input | 1 | Decode rename strobe |
| renArch | input | log2(NUM_ARCH) | Architectural register being renamed |
| renPhys | input | log2(NUM_PHYS) | New physical register |
| decBegin | input | 1 | Transaction-begin decoded |
| decPc | input | PC_W | Handler address of the decoded transaction-begin |
| gradBegin | input | 1 | Transaction-begin graduated |
| gradEnd | input | 1 | Transaction-end graduated |
| gradFree | input | 1 | Graduation frees a physical register |
| gradFreePhys | input | log2(NUM_PHYS) | Physical register being freed |
| abortReq | input | 1 | Abort the active transaction |
| mapOut | output | NUM_ARCH*log2(NUM_PHYS) | Current mapping, one slot per architectural register |
| freeMask | output | NUM_PHYS | One-cycle mask of registers returned to the free list |
| reservedOut | output | NUM_PHYS | Reserved list as a bit vector |
| txActive | output | 1 | An active snapshot exists |
| abortRestore | output | 1 | One-cycle pulse after a rollback |
| restorePc | output | PC_W | Handler address for the redirect |

## Verification
A corrupt active snapshot only shows when an abort lands: one cycle later the mapping differs from the state at the begin, or the wrong handler address appears. A bad saved vector shows earlier, on the first free after activation, when a register goes to the wrong list in the free mask or the reserved output. Reserved state that leaks or is lost shows at the outermost commit as a wrong free-mask pulse, or as a register that is both freed and reserved in the same cycle.

// File: rtl/txsnap_pkg.sv
package txsnap_pkg;

  // strobes from control to datapath, valid in the cycle they are computed
  typedef struct packed {
    logic capture;    // copy table into pending slot
    logic promote;    // pending slot becomes active snapshot
    logic commit;     // release reserved list, drop active snapshot
    logic restore;    // roll table back to active snapshot
    logic activeNow;  // active snapshot valid before this edge
  } snapCtl_t;

endpackage

// File: rtl/txsnap_ctrl.sv
module txsnap_ctrl
  import txsnap_pkg::*;
#(
  parameter int NEST_W = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     decBegin,
  input  logic     gradBegin,
  input  logic     gradEnd,
  input  logic     abortReq,
  output snapCtl_t ctl,
  output logic     txActive
);

  logic              pendingValid;
  logic              activeValid;
  logic [NEST_W-1:0] nestDepth;

  logic doAbort, promote, fold, consume, capture, commit, unnest;

  always_comb begin
    doAbort = abortReq & activeValid;
    promote = !doAbort & gradBegin & !activeValid & pendingValid;
    fold    = !doAbort & gradBegin & activeValid;
    consume = promote | fold;
    capture = !doAbort & decBegin & (!pendingValid | consume);
    commit  = !doAbort & gradEnd & activeValid & (nestDepth == '0);
    unnest  = !doAbort & gradEnd & activeValid & (nestDepth != '0);

    ctl.capture   = capture;
    ctl.promote   = promote;
    ctl.commit    = commit;
    ctl.restore   = doAbort;
    ctl.activeNow = activeValid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendingValid <= 1'b0;
      activeValid  <= 1'b0;
      nestDepth    <= '0;
    end else begin
      pendingValid <= doAbort ? 1'b0 : (capture | (pendingValid & !consume));
      if (doAbort || commit)  activeValid <= 1'b0;
      else if (promote)       activeValid <= 1'b1;
      if (doAbort || commit)  nestDepth <= '0;
      else if (fold)          nestDepth <= nestDepth + 1'b1;
      else if (unnest)        nestDepth <= nestDepth - 1'b1;
    end
  end

  assign txActive = activeValid;

endmodule

// File: rtl/txsnap_dp.sv
module txsnap_dp
  import txsnap_pkg::*;
#(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 32,
  parameter int PC_W     = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  snapCtl_t                           ctl,
  input  logic                               renValid,
  input  logic [$clog2(NUM_ARCH)-1:0]        renArch,
  input  logic [$clog2(NUM_PHYS)-1:0]        renPhys,
  input  logic [PC_W-1:0]                    decPc,
  input  logic                               gradFree,
  input  logic [$clog2(NUM_PHYS)-1:0]        gradFreePhys,
  output logic [NUM_ARCH*$clog2(NUM_PHYS)-1:0] mapOut,
  output logic [NUM_PHYS-1:0]                freeMask,
  output logic [NUM_PHYS-1:0]                reservedOut,
  output logic [NUM_PHYS-1:0]                savedOut,
  output logic                               abortRestore,
  output logic [PC_W-1:0]                    restorePc
);

  localparam int PW = $clog2(NUM_PHYS);

  logic [PW-1:0]       mapTbl  [NUM_ARCH];
  logic [PW-1:0]       pendMap [NUM_ARCH];
  logic [PW-1:0]       actMap  [NUM_ARCH];
  logic [NUM_PHYS-1:0] savedVec, pendSaved, actSaved;
  logic [PC_W-1:0]     pendPc, actPc;
  logic [NUM_PHYS-1:0] reservedVec;

  logic [NUM_PHYS-1:0] savedNext, reservedNext, freeNext;

  // saved set follows the table: new register in, displaced one out
  always_comb begin
    savedNext = savedVec;
    if (renValid) begin
      savedNext[mapTbl[renArch]] = 1'b0;
      savedNext[renPhys]         = 1'b1;
    end
  end

  // routing of freed registers between free mask and reserved list
  always_comb begin
    reservedNext = reservedVec;
    freeNext     = '0;
    if (!ctl.restore) begin
      if (ctl.commit) begin
        freeNext     = reservedVec;
        reservedNext = '0;
      end
      if (gradFree) begin
        if (ctl.activeNow && !ctl.commit && actSaved[gradFreePhys])
          reservedNext[gradFreePhys] = 1'b1;
        else
          freeNext[gradFreePhys] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++) begin
        mapTbl[i]  <= PW'(i);
        pendMap[i] <= '0;
        actMap[i]  <= '0;
      end
      for (int p = 0; p < NUM_PHYS; p++) savedVec[p] <= (p < NUM_ARCH);
      pendSaved    <= '0;
      actSaved     <= '0;
      pendPc       <= '0;
      actPc        <= '0;
      reservedVec  <= '0;
      freeMask     <= '0;
      abortRestore <= 1'b0;
      restorePc    <= '0;
    end else begin
      freeMask     <= freeNext;
      abortRestore <= ctl.restore;
      if (ctl.promote) begin
        actMap   <= pendMap;
        actSaved <= pendSaved;
        actPc    <= pendPc;
      end
      if (ctl.capture) begin
        pendMap   <= mapTbl;
        pendSaved <= savedVec;
        pendPc    <= decPc;
      end
      if (ctl.restore) begin
        mapTbl      <= actMap;
        savedVec    <= actSaved;
        restorePc   <= actPc;
        reservedVec <= '0;
      end else begin
        if (renValid) mapTbl[renArch] <= renPhys;
        savedVec    <= savedNext;
        reservedVec <= reservedNext;
      end
    end
  end

  for (genvar g = 0; g < NUM_ARCH; g++) begin : g_flat
    assign mapOut[g*PW +: PW] = mapTbl[g];
  end

  assign reservedOut = reservedVec;
  assign savedOut    = savedVec;

endmodule

// File: rtl/txsnap_top.sv
module txsnap_top
  import txsnap_pkg::*;
#(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 32,
  parameter int PC_W     = 16,
  parameter int NEST_W   = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 renValid,
  input  logic [$clog2(NUM_ARCH)-1:0]          renArch,
  input  logic [$clog2(NUM_PHYS)-1:0]          renPhys,
  input  logic                                 decBegin,
  input  logic [PC_W-1:0]                      decPc,
  input  logic                                 gradBegin,
  input  logic                                 gradEnd,
  input  logic                                 gradFree,
  input  logic [$clog2(NUM_PHYS)-1:0]          gradFreePhys,
  input  logic                                 abortReq,
  output logic [NUM_ARCH*$clog2(NUM_PHYS)-1:0] mapOut,
  output logic [NUM_PHYS-1:0]                  freeMask,
  output logic [NUM_PHYS-1:0]                  reservedOut,
  output logic                                 txActive,
  output logic                                 abortRestore,
  output logic [PC_W-1:0]                      restorePc
);

  snapCtl_t            ctl;
  logic [NUM_PHYS-1:0] savedVec;

  txsnap_ctrl #(.NEST_W(NEST_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .decBegin (decBegin),
    .gradBegin(gradBegin),
    .gradEnd  (gradEnd),
    .abortReq (abortReq),
    .ctl      (ctl),
    .txActive (txActive)
  );

  txsnap_dp #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .PC_W(PC_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl         (ctl),
    .renValid    (renValid),
    .renArch     (renArch),
    .renPhys     (renPhys),
    .decPc       (decPc),
    .gradFree    (gradFree),
    .gradFreePhys(gradFreePhys),
    .mapOut      (mapOut),
    .freeMask    (freeMask),
    .reservedOut (reservedOut),
    .savedOut    (savedVec),
    .abortRestore(abortRestore),
    .restorePc   (restorePc)
  );

endmodule

// File: rtl/txsnap_checker.sv
module txsnap_checker #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                abortReq,
  input logic                gradBegin,
  input logic                txActive,
  input logic                abortRestore,
  input logic [NUM_PHYS-1:0] freeMask,
  input logic [NUM_PHYS-1:0] reservedOut,
  input logic [NUM_PHYS-1:0] savedVec
);

  assert_saved_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(savedVec) == NUM_ARCH);

  assert_no_overlap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (freeMask & reservedOut) == '0);

  assert_reserve_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(reservedOut) <= NUM_ARCH);

  assert_reserved_in_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reservedOut != '0) |-> txActive);

  assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abortRestore |-> (!txActive && reservedOut == '0));

  assert_abort_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abortRestore |-> $past(abortReq && txActive));

  assert_activate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txActive) |-> $past(gradBegin));

endmodule

bind txsnap_top txsnap_checker #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .abortReq    (abortReq),
  .gradBegin   (gradBegin),
  .txActive    (txActive),
  .abortRestore(abortRestore),
  .freeMask    (freeMask),
  .reservedOut (reservedOut),
  .savedVec    (savedVec)
);

// File: tb/txsnap_top_tb.sv
module txsnap_top_tb;
  localparam int NA  = 8;
  localparam int NP  = 32;
  localparam int PW  = 5;
  localparam int AW  = 3;
  localparam int PCW = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic renValid = 0, decBegin = 0, gradBegin = 0, gradEnd = 0, gradFree = 0, abortReq = 0;
  logic [AW-1:0]  renArch = '0;
  logic [PW-1:0]  renPhys = '0, gradFreePhys = '0;
  logic [PCW-1:0] decPc = '0;
  logic [NA*PW-1:0] mapOut;
  logic [NP-1:0]  freeMask, reservedOut;
  logic           txActive, abortRestore;
  logic [PCW-1:0] restorePc;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [NP-1:0] expFree[$];
  int mdl[NA];
  int snapA[NA];
  int snapB[NA];

  always #5 clk = ~clk;

  txsnap_top u_dut (
    .clk(clk), .rst_n(rst_n), .renValid(renValid), .renArch(renArch), .renPhys(renPhys),
    .decBegin(decBegin), .decPc(decPc), .gradBegin(gradBegin), .gradEnd(gradEnd),
    .gradFree(gradFree), .gradFreePhys(gradFreePhys), .abortReq(abortReq),
    .mapOut(mapOut), .freeMask(freeMask), .reservedOut(reservedOut), .txActive(txActive),
    .abortRestore(abortRestore), .restorePc(restorePc)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NA*PW-1:0] flatMdl();
    logic [NA*PW-1:0] f;
    for (int i = 0; i < NA; i++) f[i*PW +: PW] = PW'(mdl[i]);
    return f;
  endfunction

  task automatic cyc();
    @(negedge clk);
    renValid = 0; decBegin = 0; gradBegin = 0; gradEnd = 0; gradFree = 0; abortReq = 0;
  endtask

  task automatic ren(int a, int p);
    renValid = 1; renArch = AW'(a); renPhys = PW'(p);
  endtask

  task automatic fre(int p);
    gradFree = 1; gradFreePhys = PW'(p);
  endtask

  // monitor: scoreboard of free-mask pulses, plus list disjointness
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R12 free/reserved overlap", 64'(freeMask & reservedOut), 64'h0);
      if (freeMask != '0) begin
        if (expFree.size() == 0) chk("R6/R7 unexpected free pulse", 64'(freeMask), 64'h0);
        else chk("R6/R7 free mask", 64'(freeMask), 64'(expFree.pop_front()));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NA; i++) mdl[i] = i;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 map", 64'(mapOut), 64'(flatMdl()));
    chk("R1 txActive", 64'(txActive), 64'h0);
    chk("R1 reserved", 64'(reservedOut), 64'h0);
    chk("R1 free", 64'(freeMask), 64'h0);
    chk("R1 abortRestore", 64'(abortRestore), 64'h0);

    // R2 rename
    ren(1, 8); cyc(); mdl[1] = 8;
    chk("R2 map after rename", 64'(mapOut), 64'(flatMdl()));
    // R6 free outside a transaction
    fre(1); expFree.push_back(NP'(1) << 1); cyc();
    chk("R6 no reserve outside tx", 64'(reservedOut), 64'h0);

    // R4 capture sees table before same-cycle rename
    snapA = mdl;
    decBegin = 1; decPc = 16'h0100; ren(2, 9); cyc(); mdl[2] = 9;
    chk("R4 map", 64'(mapOut), 64'(flatMdl()));
    chk("R4 not yet active", 64'(txActive), 64'h0);
    // R13 second begin with pending slot full is dropped
    decBegin = 1; decPc = 16'h0200; cyc();
    // R5 activation
    gradBegin = 1; cyc();
    chk("R5 active", 64'(txActive), 64'h1);

    // R6 reserve saved registers
    ren(3, 10); fre(3); cyc(); mdl[3] = 10;
    chk("R6 reserve phys3", 64'(reservedOut), 64'h8);
    fre(2); cyc();
    chk("R6 reserve phys2", 64'(reservedOut), 64'hC);
    ren(2, 11); cyc(); mdl[2] = 11;
    fre(9); expFree.push_back(NP'(1) << 9); cyc();
    chk("R6 unsaved reg freed", 64'(reservedOut), 64'hC);

    // R8 abort with same-cycle rename discarded
    abortReq = 1; ren(0, 12); cyc(); mdl = snapA;
    chk("R8 map restored", 64'(mapOut), 64'(flatMdl()));
    chk("R8 restore pulse", 64'(abortRestore), 64'h1);
    chk("R13 restorePc from first begin", 64'(restorePc), 64'h0100);
    chk("R8 inactive", 64'(txActive), 64'h0);
    chk("R8 reserved cleared", 64'(reservedOut), 64'h0);
    cyc();
    chk("R8 pulse one cycle", 64'(abortRestore), 64'h0);

    // R9 abort with nothing active
    abortReq = 1; ren(0, 13); cyc(); mdl[0] = 13;
    chk("R9 no restore pulse", 64'(abortRestore), 64'h0);
    chk("R9 rename kept", 64'(mapOut), 64'(flatMdl()));

    // R10 nesting, R7 commit, R11 run-ahead snapshot
    decBegin = 1; decPc = 16'h0300; cyc();
    gradBegin = 1; cyc();
    chk("R5 second activation", 64'(txActive), 64'h1);
    ren(4, 14); cyc(); mdl[4] = 14;
    fre(4); cyc();
    chk("R6 reserve phys4", 64'(reservedOut), 64'h10);
    gradBegin = 1; cyc();
    gradEnd = 1; cyc();
    chk("R10 inner end keeps tx", 64'(txActive), 64'h1);
    chk("R10 inner end keeps reserved", 64'(reservedOut), 64'h10);
    ren(5, 15); fre(5); cyc(); mdl[5] = 15;
    chk("R6 reserve phys5", 64'(reservedOut), 64'h30);
    snapB = mdl;
    decBegin = 1; decPc = 16'h0400; cyc();
    gradEnd = 1; fre(13);
    expFree.push_back((NP'(1) << 4) | (NP'(1) << 5) | (NP'(1) << 13)); cyc();
    chk("R7 commit clears tx", 64'(txActive), 64'h0);
    chk("R7 commit empties reserved", 64'(reservedOut), 64'h0);
    gradBegin = 1; cyc();
    chk("R11 later snapshot active", 64'(txActive), 64'h1);
    ren(6, 16); cyc(); mdl[6] = 16;
    abortReq = 1; cyc(); mdl = snapB;
    chk("R11 map restored to later snapshot", 64'(mapOut), 64'(flatMdl()));
    chk("R11 restorePc", 64'(restorePc), 64'h0400);

    repeat (3) cyc();
    chk("R7 all expected frees seen", 64'(expFree.size()), 64'h0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule